// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Access

This block is a single-slave SPI master that software runs through a small 32-bit register window. A control register picks the serial clock rate and the clock mode. A system register enables the engine and sets the chip-select level directly. Each write to the transmit register starts one 8-bit full-duplex exchange. The returned byte is held in a receive register and announced by a ready flag in the status register.

The serial clock comes from two divider stages. A coarse stage divides the core clock by 16 or by 128. A fine stage then divides that result by 2·(N+1). Software holds chip select at the level it last wrote. A driver can therefore keep the slave selected across any number of bytes and release it only when the message ends. A typical sequence is: program the control register, write the system register with enable set and chip select low, then for each byte poll the busy bit, write the transmit register, wait for ready and read the receive register.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, cs_n is 1 and sclk is 0. The control and status registers read 0 and the system register reads 0x40.
- R2: Registers sit at byte offsets 0x00 (control, bits [7:0]), 0x04 (status), 0x08 (system, bits [6:0]), 0x0C (transmit) and 0x10 (receive). Control and system read back what was written. Offset 0x14 accepts writes and always reads 0.
- R3: While a byte is in flight, each sclk half period lasts P·(N+1) core clocks. P is 16 when control bit 5 is 0 and 128 when it is 1, and N is control bits [4:0]. A byte takes exactly 16 sclk edges, and the first edge comes P·(N+1) clocks after the transmit write.
- R4: With no byte in flight, sclk rests at control bit 6 (clock polarity) from the cycle after that bit is written.
- R5: Data moves MSB first in both directions, in all four clock modes. With control bit 7 (clock phase) at 0, the first bit is on mosi before the first edge and miso is sampled on leading edges. With bit 7 at 1, mosi changes on leading edges and miso is sampled on trailing edges. The received byte reads from offset 0x10 bits [7:0].
- R6: Status bit 0 reads 1 from the cycle after an accepted transmit write through the final sclk edge, then 0. Status bit 2 becomes 1 when the byte completes.
- R7: Reading offset 0x10 clears status bit 2. So does writing the status register with bit 2 at 0. If a byte completes in the same cycle as either clear, bit 2 ends at 1.
- R8: cs_n equals system bit 6 (0 selects the slave) and changes only on a write to the system register, never because of a transfer.
- R9: A transmit write is ignored while status bit 0 is 1 or while system bit 0 (engine enable) is 0. Writing 0x21 to the system register enables the engine with the slave selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of the read strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two events can land on the same clock edge: the final sclk edge of a byte, which sets the ready flag, and a software clear of that flag, either by a receive-register read or by a status write of 0. The bench counts the exact cycle of the last edge from the programmed divider and places the read strobe, and in a second byte the status write, on that edge. It then judges that the read returned the previous byte, that the ready flag stayed 1, and that the next receive read returns the new byte. A reference model stepped on every clock also predicts sclk and cs_n for every cycle of the run.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Word index (byte offset / 4) of each register
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_SYS  = 2;
  localparam int OFS_TX   = 3;
  localparam int OFS_RX   = 4;
  localparam int OFS_AUX  = 5;

  // Status and system bit positions
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_RDY_BIT  = 2;
  localparam int SYS_W         = 7;
  localparam int SYS_EN_BIT    = 0;
  localparam int SYS_CS_BIT    = 6;
  localparam logic [SYS_W-1:0] SYS_RESET = 7'h40;

  // Coarse divider choices
  localparam int unsigned PRE_FAST = 16;
  localparam int unsigned PRE_SLOW = 128;

  // Core clocks per sclk half period
  function automatic int unsigned half_clocks(input logic pre_hi, input int unsigned n);
    return (pre_hi ? PRE_SLOW : PRE_FAST) * (n + 1);
  endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int WORD_BITS = 8,
  parameter int DIV_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic [WORD_BITS-1:0] rx_byte,
  output logic [DIV_W-1:0]     div_n,
  output logic                 pre_hi,
  output logic                 cpol,
  output logic                 cpha,
  output logic                 cs_n,
  output logic                 start,
  output logic                 rd_rx,
  output logic                 rx_rdy,
  output logic [WORD_BITS-1:0] tx_byte
);

  localparam int IDX_W  = ADDR_W - 2;
  localparam int CTRL_W = DIV_W + 3;

  logic [IDX_W-1:0]     idx;
  logic                 wr, rd;
  logic                 hit_ctrl, hit_stat, hit_sys, hit_tx, hit_rx;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [SYS_W-1:0]     sys_q;
  logic [WORD_BITS-1:0] rxbuf_q;
  logic                 rdy_q;
  logic                 stat_clr;
  logic                 unused_bits;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;
  assign hit_ctrl = (int'(idx) == OFS_CTRL);
  assign hit_stat = (int'(idx) == OFS_STAT);
  assign hit_sys  = (int'(idx) == OFS_SYS);
  assign hit_tx   = (int'(idx) == OFS_TX);
  assign hit_rx   = (int'(idx) == OFS_RX);

  assign unused_bits = ^{bus_wdata[DATA_W-1:CTRL_W], bus_addr[1:0]};

  // Control and system registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sys_q  <= SYS_RESET;
    end else if (wr) begin
      if (hit_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (hit_sys)  sys_q  <= bus_wdata[SYS_W-1:0];
    end
  end

  assign div_n  = ctrl_q[DIV_W-1:0];
  assign pre_hi = ctrl_q[DIV_W];
  assign cpol   = ctrl_q[DIV_W+1];
  assign cpha   = ctrl_q[DIV_W+2];
  assign cs_n   = sys_q[SYS_CS_BIT];

  // Transfer launch: enabled engine, idle, write to transmit word
  assign start   = wr && hit_tx && sys_q[SYS_EN_BIT] && !busy;
  assign tx_byte = bus_wdata[WORD_BITS-1:0];

  // Receive side: completion has priority over any clear
  assign rd_rx    = rd && hit_rx;
  assign stat_clr = wr && hit_stat && !bus_wdata[STAT_RDY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      if (done) begin
        rxbuf_q <= rx_byte;
        rdy_q   <= 1'b1;
      end else if (rd_rx || stat_clr) begin
        rdy_q   <= 1'b0;
      end
    end
  end

  assign rx_rdy = rdy_q;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata = DATA_W'(ctrl_q);
    end else if (hit_stat) begin
      bus_rdata[STAT_BUSY_BIT] = busy;
      bus_rdata[STAT_RDY_BIT]  = rdy_q;
    end else if (hit_sys) begin
      bus_rdata = DATA_W'(sys_q);
    end else if (hit_rx) begin
      bus_rdata = DATA_W'(rxbuf_q);
    end
  end

endmodule

// File: rtl/spim_tick_gen.sv
module spim_tick_gen #(
  parameter int HALF_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic              tick
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_q;

  assign tick = run && (cnt_q == (half_q - HALF_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= '0;
    end else begin
      if (start) half_q <= half_len;
      if (start || tick || !run) cnt_q <= '0;
      else                       cnt_q <= cnt_q + HALF_W'(1);
    end
  end

endmodule

// File: rtl/spim_shift_engine.sv
module spim_shift_engine #(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WORD_BITS-1:0] tx_byte,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic                 tick,
  input  logic                 miso,
  output logic                 busy,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 done,
  output logic [WORD_BITS-1:0] rx_byte
);

  localparam int N_EDGES   = 2 * WORD_BITS;
  localparam int EDGE_W    = $clog2(N_EDGES);
  localparam int LAST_EDGE = N_EDGES - 1;

  logic [EDGE_W-1:0]    edge_q;
  logic [WORD_BITS-1:0] sh_q;
  logic [WORD_BITS-1:0] rx_q;
  logic                 busy_q, sclk_q, mosi_q, cpha_q;
  logic                 lead;
  logic                 sample_edge, shift_edge;

  assign lead        = ~edge_q[0];
  assign sample_edge = tick && (lead ^ cpha_q);
  assign shift_edge  = tick && !(lead ^ cpha_q);
  assign done        = tick && (edge_q == EDGE_W'(LAST_EDGE));
  assign rx_byte     = sample_edge ? {rx_q[WORD_BITS-2:0], miso} : rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      cpha_q <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      edge_q <= '0;
      sclk_q <= cpol;
      cpha_q <= cpha;
      rx_q   <= '0;
      if (!cpha) begin
        mosi_q <= tx_byte[WORD_BITS-1];
        sh_q   <= {tx_byte[WORD_BITS-2:0], 1'b0};
      end else begin
        sh_q   <= tx_byte;
      end
    end else if (busy_q) begin
      if (tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + EDGE_W'(1);
        if (done)        busy_q <= 1'b0;
        if (sample_edge) rx_q   <= rx_byte;
        if (shift_edge) begin
          mosi_q <= sh_q[WORD_BITS-1];
          sh_q   <= {sh_q[WORD_BITS-2:0], 1'b0};
        end
      end
    end else begin
      sclk_q <= cpol;
    end
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = mosi_q;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int WORD_BITS = 8,
  parameter int DIV_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int HALF_W = $clog2(PRE_SLOW) + DIV_W + 1;

  logic [DIV_W-1:0]     div_n_w;
  logic                 pre_hi_w, cpol_w, cpha_w;
  logic                 start_w, busy_w, tick_w, done_w;
  logic                 rd_rx_w, rx_rdy_w;
  logic [WORD_BITS-1:0] tx_byte_w, rx_byte_w;
  logic [HALF_W-1:0]    half_w;

  assign half_w = HALF_W'(half_clocks(pre_hi_w, 32'(div_n_w)));

  spim_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BITS(WORD_BITS), .DIV_W(DIV_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .done(done_w), .rx_byte(rx_byte_w),
    .div_n(div_n_w), .pre_hi(pre_hi_w), .cpol(cpol_w), .cpha(cpha_w),
    .cs_n(cs_n), .start(start_w), .rd_rx(rd_rx_w), .rx_rdy(rx_rdy_w),
    .tx_byte(tx_byte_w)
  );

  spim_tick_gen #(.HALF_W(HALF_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .start(start_w), .run(busy_w),
    .half_len(half_w), .tick(tick_w)
  );

  spim_shift_engine #(.WORD_BITS(WORD_BITS)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start_w), .tx_byte(tx_byte_w),
    .cpol(cpol_w), .cpha(cpha_w), .tick(tick_w), .miso(miso),
    .busy(busy_w), .sclk(sclk), .mosi(mosi), .done(done_w),
    .rx_byte(rx_byte_w)
  );

endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cs_n,
  input logic              sclk,
  input logic              busy,
  input logic              tick,
  input logic              done,
  input logic              rx_rdy,
  input logic              rd_rx,
  input logic              start
);

  logic sys_wr;
  assign sys_wr = bus_en && bus_we && (int'(bus_addr[ADDR_W-1:2]) == 2);

  p_cs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_wr |=> $stable(cs_n));

  p_sclk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_done_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rx_rdy && !busy));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !done) |=> !rx_rdy);

  p_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

bind spi_byte_master spim_checker #(.ADDR_W(ADDR_W)) u_spim_checker (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .cs_n(cs_n), .sclk(sclk), .busy(busy_w),
  .tick(tick_w), .done(done_w), .rx_rdy(rx_rdy_w), .rd_rx(rd_rx_w),
  .start(start_w)
);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SYS = 5'h08,
                         A_TX = 5'h0C, A_RX = 5'h10, A_AUX = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model, stepped each clock ----------------
  bit   m_busy, m_sclk, m_cs, m_en, wb;
  logic [7:0] m_ctrl;
  int   m_cnt, m_edges, m_half;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sclk = 0; m_cs = 1; m_en = 0; m_ctrl = 0;
      m_cnt = 0; m_edges = 0; m_half = 16;
    end else begin
      wb = m_busy;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_half) begin
          m_cnt = 0; m_sclk = !m_sclk; m_edges++;
          if (m_edges == 16) m_busy = 0;
        end
      end else begin
        m_sclk = m_ctrl[6];
      end
      if (bus_en && bus_we) begin
        if (bus_addr == A_CTRL) m_ctrl = bus_wdata[7:0];
        else if (bus_addr == A_SYS) begin m_cs = bus_wdata[6]; m_en = bus_wdata[0]; end
        else if (bus_addr == A_TX && m_en && !wb) begin
          m_busy = 1; m_cnt = 0; m_edges = 0; m_sclk = m_ctrl[6];
          m_half = (m_ctrl[5] ? 128 : 16) * (int'(m_ctrl[4:0]) + 1);
        end
      end
    end
  end

  // R3 R4 R8: sclk and cs_n compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      n_chk++;
      if (sclk !== m_sclk || cs_n !== m_cs) begin
        n_fail++;
        $display("FAIL R3/R4/R8 cycle compare: sclk=%0b cs_n=%0b expected sclk=%0b cs_n=%0b",
                 sclk, cs_n, m_sclk, m_cs);
      end
    end
  end

  // ---------------- slave model ----------------
  bit        sl_active = 0, sl_cpha = 0;
  logic      sl_prev = 0;
  logic [7:0] sl_pat = 0, cap = 0;
  int        sl_edge = 0;

  always @(negedge clk) begin
    if (sl_active && sclk !== sl_prev) begin
      if ((sl_edge % 2 == 0) != sl_cpha) cap = {cap[6:0], mosi};
      else if (sl_cpha)                  miso = sl_pat[7 - sl_edge/2];
      else if (sl_edge < 15)             miso = sl_pat[6 - sl_edge/2];
      sl_edge++;
      if (sl_edge == 16) sl_active = 0;
    end
    sl_prev = sclk;
  end

  // ---------------- tasks ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic arm_slave(input logic [7:0] pat, input bit cpha_v);
    sl_pat = pat; sl_cpha = cpha_v; sl_edge = 0; cap = 0;
    miso = cpha_v ? 1'b0 : pat[7];
    sl_active = 1;
  endtask

  task automatic wait_slave();
    while (sl_active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] ctrl_v, input logic [7:0] tx, input logic [7:0] pat, input string tag);
    logic [31:0] d;
    bus_write(A_CTRL, {24'h0, ctrl_v});
    repeat (2) @(negedge clk);
    arm_slave(pat, ctrl_v[7]);
    bus_write(A_TX, {24'h0, tx});
    bus_read(A_STAT, d);
    chk(d[0] == 1'b1 && d[2] == 1'b0, {"R6 busy during ", tag}, d, 32'h1);
    wait_slave();
    chk(cap == tx, {"R5 mosi byte ", tag}, cap, tx);
    bus_read(A_STAT, d);
    chk(d == 32'h4, {"R6 ready after ", tag}, d, 32'h4);
    bus_read(A_RX, d);
    chk(d == {24'h0, pat}, {"R5 rx byte ", tag}, d, pat);
    bus_read(A_STAT, d);
    chk(d == 32'h0, {"R7 read clears ready ", tag}, d, 32'h0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 pins", {cs_n, sclk}, 32'h2);
    bus_read(A_CTRL, d); chk(d == 0, "R1 ctrl", d, 0);
    bus_read(A_STAT, d); chk(d == 0, "R1 status", d, 0);
    bus_read(A_SYS, d);  chk(d == 32'h40, "R1 system", d, 32'h40);

    // R2 readback
    bus_write(A_CTRL, 32'hFFFF_FFAB);
    bus_read(A_CTRL, d); chk(d == 32'hAB, "R2 ctrl readback", d, 32'hAB);
    bus_write(A_AUX, 32'hFFFF_FFFF);
    bus_read(A_AUX, d);  chk(d == 0, "R2 aux reads zero", d, 0);
    bus_write(A_CTRL, 0);

    // R9 disabled engine ignores transmit; R8 cs low without enable
    bus_write(A_SYS, 32'h00);
    chk(cs_n == 1'b0, "R8 cs follows bit6", cs_n, 0);
    bus_write(A_TX, 32'h55);
    bus_read(A_STAT, d); chk(d == 0, "R9 disabled no start", d, 0);

    // R9 enable with manual select
    bus_write(A_SYS, 32'h21);
    bus_read(A_SYS, d); chk(d == 32'h21 && cs_n == 1'b0, "R9 enable value", d, 32'h21);

    // R5 four modes, R3 several dividers
    xfer(8'h00, 8'hA5, 8'h3C, "mode0 N0");
    xfer(8'h82, 8'h96, 8'hE1, "mode1 N2");
    xfer(8'h41, 8'h0F, 8'hC3, "mode2 N1");
    chk(sclk == 1'b1, "R4 idle high", sclk, 1);
    xfer(8'hC3, 8'h81, 8'h7E, "mode3 N3");
    xfer(8'h21, 8'h6B, 8'h94, "slow prescaler");
    chk(cs_n == 1'b0, "R8 cs held across bytes", cs_n, 0);

    // R9 write while busy ignored
    bus_write(A_CTRL, 0);
    repeat (2) @(negedge clk);
    arm_slave(8'h18, 1'b0);
    bus_write(A_TX, 32'h5A);
    repeat (20) @(negedge clk);
    bus_write(A_TX, 32'hFF);
    wait_slave();
    chk(cap == 8'h5A, "R9 busy write ignored", cap, 8'h5A);
    bus_read(A_RX, d); chk(d == 32'h18, "R9 rx intact", d, 32'h18);

    // R7 collision: rx read on completion edge (half = 16)
    arm_slave(8'hD2, 1'b0);
    bus_write(A_TX, 32'h33);
    repeat (16*16 - 1) @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = A_RX;
    #1 d = bus_rdata;
    chk(d == 32'h18, "R7 collision read old data", d, 32'h18);
    @(negedge clk); bus_en = 0;
    bus_read(A_STAT, d); chk(d == 32'h4, "R7 completion beats read clear", d, 32'h4);
    bus_read(A_RX, d);   chk(d == 32'hD2, "R7 new byte kept", d, 32'hD2);
    wait_slave();

    // R7 status write clear, then collision with status write
    arm_slave(8'h4E, 1'b0);
    bus_write(A_TX, 32'hC7);
    wait_slave();
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); chk(d == 0, "R7 status write clears", d, 0);
    arm_slave(8'hB1, 1'b0);
    bus_write(A_TX, 32'h1E);
    repeat (16*16 - 1) @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = A_STAT; bus_wdata = 0;
    @(negedge clk); bus_en = 0; bus_we = 0;
    bus_read(A_STAT, d); chk(d == 32'h4, "R7 completion beats status clear", d, 32'h4);
    wait_slave();
    chk(cap == 8'h1E, "R5 mosi collision byte", cap, 8'h1E);

    // R8 deselect
    bus_write(A_SYS, 32'h61);
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1, "R8 deselect", cs_n, 1);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", MAX_CYCLES);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule